// File: doc/BRIEF.md
# Self-Clearing Command Sequencer for a Serial Sensor Master

This block holds the command register that a host writes to steer a serial sensor master, and runs the short sequence each command needs. The host can ask for a single sensor read that ends with either control level, a register transfer, a sensor initialisation, or a continuous run of sensor reads. It can also abort whatever is running. For every request the block issues a start pulse to the frame engine, tells the engine which kind of frame to run, and keeps the line clock enabled until the engine reports completion. When that happens, the block clears the command bit it has just served.

Between frames a reloadable down-counter enforces a minimum quiet time on the line, and no new frame starts until the counter reaches zero. The block also reports how many register bytes the last register transfer delivered intact before an error. It raises a swap pulse for the sensor data banks when a sensor frame completes, unless the host has frozen the banks. Toggling the force bit also raises a swap pulse.

Top module: `cmdreg_seq`

## Requirements
- R1: After reset `cmd_rd` reads 0, `cdt_elapsed` reads 1, `good_bytes` reads 0, and `frm_start`, `frm_stop`, `line_clk_en` and `bank_swap` are all 0.
- R2: The command layout is as follows. Bit 0 is abort, bit 1 is init, bit 2 is register transfer, bit 3 is a sensor read ending with control level 0, and bit 4 is a sensor read ending with control level 1. These five bits are one-shot: a written 1 sets the bit and a written 0 leaves it unchanged. Bit 5 is auto mode, bit 6 is bank hold and bit 7 is bank force. These three bits take the written value on every write.
- R3: One cycle after the frame engine reports done, the one-shot bit that started the frame reads 0. All other bits keep their values.
- R4: When several requests are pending, frames start in this order: init, register transfer, sensor read with level 0, sensor read with level 1, then auto mode. `frm_kind` is 0 for a sensor frame, 1 for a register frame and 2 for an init frame.
- R5: `frm_cdm` is 0 for a bit-3 request and for auto-mode frames, and 1 for a bit-4 request.
- R6: Each completed frame, and each abort, reloads the quiet-time counter from `cdt_reload`. `cdt_elapsed` then reads 0 for exactly `cdt_reload` cycles and 1 afterwards.
- R7: `frm_start` is never 1 while `cdt_elapsed` is 0.
- R8: An abort drops `line_clk_en` in the cycle after the write. One cycle later `frm_stop` pulses for one cycle, with the abort bit still reading 1. After that pulse, bits 0 to 5 read 0 and the block is idle.
- R9: When a register frame completes without error, `good_bytes` becomes 0. When it completes with `frm_err`, `good_bytes` takes `frm_bytes_ok`. Sensor and init frames leave `good_bytes` unchanged.
- R10: While bit 5 is set, sensor frames with `frm_kind` 0 restart after each quiet time without any further host writes, and bit 5 stays set.
- R11: `bank_swap` pulses for one cycle after a sensor frame completes with bit 6 at 0, and stays 0 if bit 6 is 1. It also pulses in the cycle after any write that changes bit 7.
- R12: `frm_start` is a single-cycle pulse. `line_clk_en` is 1 from that cycle until done or abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe for the command register |
| wr_data | input | 8 | Host write data |
| cdt_reload | input | CDT_W | Quiet-time length in cycles |
| frm_done | input | 1 | Frame engine reports the frame finished |
| frm_err | input | 1 | Frame finished with an error (valid with done) |
| frm_bytes_ok | input | BYTE_W | Register bytes received intact (valid with done) |
| cmd_rd | output | 8 | Command register read-back |
| cdt_elapsed | output | 1 | Quiet time over |
| good_bytes | output | BYTE_W | Intact register bytes of the last register frame |
| frm_start | output | 1 | Start pulse to the frame engine |
| frm_kind | output | 2 | Frame type: 0 sensor, 1 register, 2 init |
| frm_cdm | output | 1 | Control level that ends the frame |
| frm_stop | output | 1 | Abort pulse to the frame engine |
| line_clk_en | output | 1 | Line clock gate enable |
| bank_swap | output | 1 | Sensor data bank swap pulse |

## Verification
A wrong sequencer state shows up one or two cycles after the cause, through three signals. A start pulse may arrive with the wrong kind or control level, or at an unexpected time. The line clock gate may stay on after an abort. A stop pulse may be missing. A command bit that fails to clear, or that clears too early, is visible at once on `cmd_rd`. It also shows up as a repeated or a lost frame at the next start. A counter that is off by one shows as a quiet time one cycle longer or shorter than `cdt_reload`, measured from the cycle after done.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

    localparam int CMD_W   = 8;

    localparam int B_ABORT = 0;
    localparam int B_INIT  = 1;
    localparam int B_REG   = 2;
    localparam int B_SNS0  = 3;
    localparam int B_SNS1  = 4;
    localparam int B_AUTO  = 5;
    localparam int B_HOLD  = 6;
    localparam int B_FORCE = 7;

    // bits that keep their written value instead of clearing themselves
    localparam logic [CMD_W-1:0] KEEP_MASK = (CMD_W'(1) << B_AUTO)
                                           | (CMD_W'(1) << B_HOLD)
                                           | (CMD_W'(1) << B_FORCE);
    // persistent bits that an abort still wipes
    localparam logic [CMD_W-1:0] WIPE_KEEP = (CMD_W'(1) << B_AUTO);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_RUN    = 2'd2,
        ST_ABORT  = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        FK_SENSOR   = 2'd0,
        FK_REGISTER = 2'd1,
        FK_INIT     = 2'd2
    } frame_kind_t;

endpackage

// File: rtl/cmdreg_bits.sv
module cmdreg_bits
    import cmdreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CMD_W-1:0] wr_data,
    input  logic [CMD_W-1:0] clr_mask,
    input  logic             wipe,
    output logic [CMD_W-1:0] cmd,
    output logic             force_flip
);

    for (genvar i = 0; i < CMD_W; i++) begin : g_bit
        logic q;
        if (KEEP_MASK[i]) begin : g_keep
            // persistent bit: follows each write; abort wipes auto mode
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= 1'b0;
                end else if (wipe && WIPE_KEEP[i]) begin
                    q <= 1'b0;
                end else if (wr_en) begin
                    q <= wr_data[i];
                end
            end
        end else begin : g_shot
            // one-shot bit: set by a written 1, cleared by its own completion
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q <= 1'b0;
                end else if (wipe || clr_mask[i]) begin
                    q <= 1'b0;
                end else if (wr_en && wr_data[i]) begin
                    q <= 1'b1;
                end
            end
        end
        assign cmd[i] = q;
    end

    // a write that changes the force bit requests one bank swap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            force_flip <= 1'b0;
        end else begin
            force_flip <= wr_en && (wr_data[B_FORCE] != cmd[B_FORCE]);
        end
    end

endmodule

// File: rtl/cmdreg_cdt.sv
module cmdreg_cdt #(
    parameter int CDT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CDT_W-1:0] reload,
    output logic             elapsed
);

    logic [CDT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= reload;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CDT_W'(1);
        end
    end

    assign elapsed = (cnt_q == '0);

endmodule

// File: rtl/cmdreg_fsm.sv
module cmdreg_fsm
    import cmdreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CMD_W-1:0] cmd,
    input  logic             elapsed,
    input  logic             frm_done,
    output seq_state_t       state,
    output frame_kind_t      kind,
    output logic             cdm,
    output logic             frm_start,
    output logic             frm_stop,
    output logic             line_clk_en,
    output logic             frame_end,
    output logic             wipe,
    output logic             cdt_load,
    output logic [CMD_W-1:0] clr_mask
);

    seq_state_t       state_q, state_d;
    frame_kind_t      kind_q, sel_kind;
    logic             cdm_q, sel_cdm;
    logic [CMD_W-1:0] mask_q, sel_mask;
    logic             want;
    logic             abort_req;

    assign abort_req = cmd[B_ABORT];

    // fixed-priority choice among pending requests
    always_comb begin
        want     = 1'b1;
        sel_kind = FK_SENSOR;
        sel_cdm  = 1'b0;
        sel_mask = '0;
        if (cmd[B_INIT]) begin
            sel_kind         = FK_INIT;
            sel_mask[B_INIT] = 1'b1;
        end else if (cmd[B_REG]) begin
            sel_kind        = FK_REGISTER;
            sel_mask[B_REG] = 1'b1;
        end else if (cmd[B_SNS0]) begin
            sel_mask[B_SNS0] = 1'b1;
        end else if (cmd[B_SNS1]) begin
            sel_cdm          = 1'b1;
            sel_mask[B_SNS1] = 1'b1;
        end else if (!cmd[B_AUTO]) begin
            want = 1'b0;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (abort_req) begin
                    state_d = ST_ABORT;
                end else if (want && elapsed) begin
                    state_d = ST_LAUNCH;
                end
            end
            ST_LAUNCH: begin
                state_d = abort_req ? ST_ABORT : ST_RUN;
            end
            ST_RUN: begin
                if (abort_req) begin
                    state_d = ST_ABORT;
                end else if (frm_done) begin
                    state_d = ST_IDLE;
                end
            end
            ST_ABORT: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register with the frame descriptor latched at launch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= FK_SENSOR;
            cdm_q   <= 1'b0;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_LAUNCH) begin
                kind_q <= sel_kind;
                cdm_q  <= sel_cdm;
                mask_q <= sel_mask;
            end
        end
    end

    // outputs
    always_comb begin
        frm_start   = (state_q == ST_LAUNCH);
        frm_stop    = (state_q == ST_ABORT);
        wipe        = (state_q == ST_ABORT);
        line_clk_en = ((state_q == ST_LAUNCH) || (state_q == ST_RUN)) && !abort_req;
        frame_end   = (state_q == ST_RUN) && !abort_req && frm_done;
        clr_mask    = frame_end ? mask_q : '0;
        cdt_load    = frame_end || (state_q == ST_ABORT);
    end

    assign state = state_q;
    assign kind  = kind_q;
    assign cdm   = cdm_q;

endmodule

// File: rtl/cmdreg_seq.sv
module cmdreg_seq
    import cmdreg_pkg::*;
#(
    parameter int CDT_W  = 8,
    parameter int BYTE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic [CDT_W-1:0]  cdt_reload,
    input  logic              frm_done,
    input  logic              frm_err,
    input  logic [BYTE_W-1:0] frm_bytes_ok,
    output logic [7:0]        cmd_rd,
    output logic              cdt_elapsed,
    output logic [BYTE_W-1:0] good_bytes,
    output logic              frm_start,
    output logic [1:0]        frm_kind,
    output logic              frm_cdm,
    output logic              frm_stop,
    output logic              line_clk_en,
    output logic              bank_swap
);

    logic [CMD_W-1:0] cmd;
    logic [CMD_W-1:0] clr_mask;
    logic             wipe;
    logic             force_flip;
    logic             cdt_load;
    logic             frame_end;
    seq_state_t       state;
    frame_kind_t      kind;
    logic             cdm;
    logic [BYTE_W-1:0] bytes_q;
    logic             sens_swap_q;

    cmdreg_bits u_bits (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .clr_mask   (clr_mask),
        .wipe       (wipe),
        .cmd        (cmd),
        .force_flip (force_flip)
    );

    cmdreg_cdt #(.CDT_W(CDT_W)) u_cdt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (cdt_load),
        .reload  (cdt_reload),
        .elapsed (cdt_elapsed)
    );

    cmdreg_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (cmd),
        .elapsed     (cdt_elapsed),
        .frm_done    (frm_done),
        .state       (state),
        .kind        (kind),
        .cdm         (cdm),
        .frm_start   (frm_start),
        .frm_stop    (frm_stop),
        .line_clk_en (line_clk_en),
        .frame_end   (frame_end),
        .wipe        (wipe),
        .cdt_load    (cdt_load),
        .clr_mask    (clr_mask)
    );

    // intact-byte report and bank-swap request after sensor frames
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bytes_q     <= '0;
            sens_swap_q <= 1'b0;
        end else begin
            if (frame_end && kind == FK_REGISTER) begin
                bytes_q <= frm_err ? frm_bytes_ok : '0;
            end
            sens_swap_q <= frame_end && (kind == FK_SENSOR) && !cmd[B_HOLD];
        end
    end

    assign cmd_rd     = cmd;
    assign good_bytes = bytes_q;
    assign frm_kind   = kind;
    assign frm_cdm    = cdm;
    assign bank_swap  = sens_swap_q || force_flip;

endmodule

// File: rtl/cmdreg_seq_chk.sv
module cmdreg_seq_chk #(
    parameter int CDT_W  = 8,
    parameter int BYTE_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frm_done,
    input logic [CDT_W-1:0]  cdt_reload,
    input logic [7:0]        cmd_rd,
    input logic              cdt_elapsed,
    input logic [BYTE_W-1:0] good_bytes,
    input logic              frm_start,
    input logic              frm_stop,
    input logic              line_clk_en
);

    AST_START_NEEDS_ELAPSED: assert property (@(posedge clk) disable iff (!rst_n)
        frm_start |-> cdt_elapsed); // R7
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frm_start |=> !frm_start); // R12
    AST_STOP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frm_stop |=> !frm_stop); // R8
    AST_STOP_NO_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        frm_stop |-> !line_clk_en); // R8
    AST_ABORT_WIPES: assert property (@(posedge clk) disable iff (!rst_n)
        frm_stop |=> (cmd_rd[5:0] == 6'd0)); // R8
    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (line_clk_en && !frm_start && frm_done && cdt_reload != '0) |=> !cdt_elapsed); // R6
    AST_BYTES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_done |=> $stable(good_bytes)); // R9

endmodule

bind cmdreg_seq cmdreg_seq_chk #(.CDT_W(CDT_W), .BYTE_W(BYTE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frm_done    (frm_done),
    .cdt_reload  (cdt_reload),
    .cmd_rd      (cmd_rd),
    .cdt_elapsed (cdt_elapsed),
    .good_bytes  (good_bytes),
    .frm_start   (frm_start),
    .frm_stop    (frm_stop),
    .line_clk_en (line_clk_en)
);

// File: tb/cmdreg_seq_test.sv
`timescale 1ns/1ps
module cmdreg_seq_test;

    localparam int CDT_W  = 8;
    localparam int BYTE_W = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [7:0]        wr_data = '0;
    logic [CDT_W-1:0]  cdt_reload = 8'd4;
    logic              frm_done = 1'b0;
    logic              frm_err = 1'b0;
    logic [BYTE_W-1:0] frm_bytes_ok = '0;
    logic [7:0]        cmd_rd;
    logic              cdt_elapsed;
    logic [BYTE_W-1:0] good_bytes;
    logic              frm_start;
    logic [1:0]        frm_kind;
    logic              frm_cdm;
    logic              frm_stop;
    logic              line_clk_en;
    logic              bank_swap;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    // expected frame descriptors {kind, cdm}
    logic [2:0] exp_q[$];

    always #2 clk = ~clk;

    cmdreg_seq #(.CDT_W(CDT_W), .BYTE_W(BYTE_W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .cdt_reload   (cdt_reload),
        .frm_done     (frm_done),
        .frm_err      (frm_err),
        .frm_bytes_ok (frm_bytes_ok),
        .cmd_rd       (cmd_rd),
        .cdt_elapsed  (cdt_elapsed),
        .good_bytes   (good_bytes),
        .frm_start    (frm_start),
        .frm_kind     (frm_kind),
        .frm_cdm      (frm_cdm),
        .frm_stop     (frm_stop),
        .line_clk_en  (line_clk_en),
        .bank_swap    (bank_swap)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic host_write(input logic [7:0] d);
        wr_en   = 1'b1;
        wr_data = d;
        tick();
        wr_en   = 1'b0;
    endtask

    // frame engine model: wait for the start pulse, then report done
    task automatic serve(input logic err, input logic [BYTE_W-1:0] nbytes);
        while (!frm_start) tick();
        tick();
        chk("R12 line clock on while running", 32'(line_clk_en), 32'd1);
        frm_done     = 1'b1;
        frm_err      = err;
        frm_bytes_ok = nbytes;
        tick();
        frm_done     = 1'b0;
        frm_err      = 1'b0;
        frm_bytes_ok = '0;
    endtask

    task automatic measure_quiet(input int expect_len);
        int len = 0;
        while (!cdt_elapsed && len < 1000) begin
            if (frm_start) begin
                n_chk++;
                n_fail++;
                $display("FAIL R7: actual start during quiet time expected none");
            end
            len++;
            tick();
        end
        chk("R6 quiet length", 32'(len), 32'(expect_len));
    endtask

    // monitor: every start pulse is compared with the next expected item
    always @(negedge clk) begin
        if (rst_n && frm_start) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R4: actual start kind %0d cdm %0d expected none",
                         frm_kind, frm_cdm);
            end else begin
                logic [2:0] e;
                e = exp_q.pop_front();
                if ({frm_kind, frm_cdm} !== e) begin
                    n_fail++;
                    $display("FAIL R4/R5: actual kind %0d cdm %0d expected kind %0d cdm %0d",
                             frm_kind, frm_cdm, e[2:1], e[0]);
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_fail++;
            $display("FAIL watchdog: actual hung run expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1
        chk("R1 cmd", 32'(cmd_rd), 32'h0);
        chk("R1 elapsed", 32'(cdt_elapsed), 32'd1);
        chk("R1 bytes", 32'(good_bytes), 32'd0);
        chk("R1 outputs", {28'd0, frm_start, frm_stop, line_clk_en, bank_swap}, 32'd0);

        // sensor read, level 0, banks free
        exp_q.push_back({2'd0, 1'b0});
        host_write(8'h08);
        serve(1'b0, '0);
        chk("R3 bit cleared", 32'(cmd_rd), 32'h0);
        chk("R11 swap after sensor frame", 32'(bank_swap), 32'd1);
        measure_quiet(4);

        // sensor read, level 1, banks held, longer quiet time
        cdt_reload = 8'd9;
        exp_q.push_back({2'd0, 1'b1});
        host_write(8'h50);
        serve(1'b0, '0);
        chk("R3 hold bit stays", 32'(cmd_rd), 32'h40);
        chk("R11 no swap while held", 32'(bank_swap), 32'd0);
        measure_quiet(9);
        cdt_reload = 8'd4;

        // all one-shot requests at once: priority order
        exp_q.push_back({2'd2, 1'b0});
        exp_q.push_back({2'd1, 1'b0});
        exp_q.push_back({2'd0, 1'b0});
        exp_q.push_back({2'd0, 1'b1});
        host_write(8'h5E);
        host_write(8'h40);
        chk("R2 written zeros leave one-shots", 32'(cmd_rd), 32'h5E);
        serve(1'b0, '0);
        chk("R3 init served first", 32'(cmd_rd), 32'h5C);
        serve(1'b1, 5'd7);
        chk("R9 bytes on error", 32'(good_bytes), 32'd7);
        chk("R3 register bit cleared", 32'(cmd_rd), 32'h58);
        serve(1'b0, '0);
        chk("R9 sensor frame keeps bytes", 32'(good_bytes), 32'd7);
        serve(1'b0, '0);
        chk("R4 all served", 32'(cmd_rd), 32'h40);
        exp_q.push_back({2'd1, 1'b0});
        host_write(8'h44);
        serve(1'b0, 5'd3);
        chk("R9 clean register frame", 32'(good_bytes), 32'd0);
        measure_quiet(4);

        // force bit toggles
        host_write(8'hC0);
        chk("R11 swap on force set", 32'(bank_swap), 32'd1);
        tick();
        chk("R11 swap one cycle", 32'(bank_swap), 32'd0);
        host_write(8'h00);
        chk("R11 swap on force clear", 32'(bank_swap), 32'd1);
        chk("R2 persistent bits follow write", 32'(cmd_rd), 32'h0);

        // auto mode
        repeat (3) exp_q.push_back({2'd0, 1'b0});
        host_write(8'h20);
        serve(1'b0, '0);
        serve(1'b0, '0);
        serve(1'b0, '0);
        chk("R10 auto bit stays", 32'(cmd_rd), 32'h20);
        host_write(8'h00);
        repeat (12) tick();
        chk("R10 three auto frames", 32'(exp_q.size()), 32'd0);

        // abort while running, with init and auto also written
        exp_q.push_back({2'd0, 1'b0});
        host_write(8'h08);
        while (!frm_start) tick();
        tick();
        chk("R12 running before abort", 32'(line_clk_en), 32'd1);
        host_write(8'h23);
        chk("R8 clock stops next cycle", 32'(line_clk_en), 32'd0);
        chk("R8 no stop yet", 32'(frm_stop), 32'd0);
        tick();
        chk("R8 stop pulse", 32'(frm_stop), 32'd1);
        chk("R8 abort bit visible", 32'(cmd_rd[0]), 32'd1);
        tick();
        chk("R8 stop ends", 32'(frm_stop), 32'd0);
        chk("R8 bits wiped", 32'(cmd_rd), 32'h0);
        chk("R6 abort reloads quiet time", 32'(cdt_elapsed), 32'd0);
        repeat (12) tick();
        chk("R8 idle after abort", 32'(line_clk_en), 32'd0);
        chk("R4 no stray frames", 32'(exp_q.size()), 32'd0);

        summary();
        $finish;
    end

endmodule